// File: doc/BRIEF.md
# Sub-audio signalling serial register interface

This block is the control port of a sub-audio signalling device. A host addresses it over a synchronous serial link with a clock, a data-in line, a tri-stated data-out line and an active-low chip select. Every framed transfer opens with one opcode byte. The opcode selects a register and fixes how many data bytes follow: one or two bytes written into a register, or one or two bytes returned on the reply line. A strap input moves the opcode window, so two devices can share the same wires and still be told apart. One opcode works for both strap settings and returns the control and status registers to zero.

The serial inputs are brought into the core clock domain through a short synchroniser. A bit is taken on each rising serial clock edge, most significant bit first. Each byte is acted on as soon as its eighth bit arrives. A status word gathers event flags raised by the signalling blocks. When interrupts are enabled, any set flag pulls the open-drain interrupt line low. Reading the status word clears its two measurement flags. The written registers and their strobes leave the block as parallel ports.

Top module: `sig_regif`

## Requirements
- R1: After reset the control, frequency, gain and transmit-data registers read zero, the reply line is not driven and the interrupt line floats.
- R2: With the strap at 0 the opcodes are 70h control write, 71h status read, 72h measured-frequency read (2 bytes), 73h frequency/rate write (2 bytes), 74h receive-data read, 75h transmit-data write and 76h gain write. All others carry one byte.
- R3: With the strap at 1 the same commands sit at 78h..7Eh, and the strap-0 opcodes are ignored.
- R4: The 2-byte frequency write loads its first byte into bits 15:8 and its second into bits 7:0. Bit 11 is always stored as 0. Each byte takes effect when it completes, even if chip select rises before the next one.
- R5: The measured-frequency read returns bits 15:8 first, then bits 7:0, each MSB first.
- R6: The status read returns {2'b00, status[5:0]}. Status bits 1:0 then clear, and bits 5:2 keep their value.
- R7: The interrupt output is driven low exactly when control bit 2 is 1 and any status bit 5:0 is set.
- R8: Opcode 01h, under either strap, clears control and status to zero and leaves the frequency, gain and transmit-data registers unchanged.
- R9: The reply line is driven only while the bytes of a read command are being sent, and never while chip select is high.
- R10: Bytes beyond a command's defined count are ignored until chip select rises.
- R11: An unrecognised opcode changes no register and never drives the reply line.
- R12: A byte cut short by chip select rising has no effect.
- R13: A transmit-data write gives exactly one write strobe with the byte. A receive-data read gives exactly one read strobe and returns the receive byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap that selects the opcode window |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| cmd_in | input | 1 | Serial command data, MSB first |
| reply_out | output | 1 | Serial reply data, high impedance when idle |
| reply_en | output | 1 | High while reply_out is driven |
| irq_n | output | 1 | Open-drain interrupt, low when active, floating otherwise |
| irq_en | output | 1 | High while irq_n pulls low |
| ctrl_q | output | 8 | Control register |
| txfreq_q | output | 16 | Filter code and divider word for the tone / rate generator |
| gain_q | output | 8 | Transmit gain register |
| txdata_q | output | 8 | Last transmit data byte |
| txdata_wr | output | 1 | One-cycle strobe on a transmit-data write |
| rxfreq_in | input | 16 | Measured tone frequency word |
| rxdata_in | input | 8 | Received data byte |
| rxdata_rd | output | 1 | One-cycle strobe when the receive byte is read |
| stat_set | input | 6 | Event pulses that set status bits |
| stat_clr | input | 6 | Pulses that clear status bits |

## Verification
The embedded properties watch, on every cycle, that the reply driver switches off once the frame ends and that a cut frame produces no byte. They also check that a status read leaves the two measurement flags clear unless a new event arrives at the same moment, that a general reset empties the status word, that surplus bytes leave the registers untouched, and that the transmit strobe never lasts longer than one cycle. Only the bench's framed transfers can show the other behaviours. These are the opcode windows under each strap, the byte order and bit-11 masking of the frequency word, the content of the reply bytes, the partial-frame effects, and the interrupt level that follows from the model's status and control values.

// File: rtl/sig_regif_pkg.sv
package sig_regif_pkg;

    localparam int BYTE_W = 8;
    localparam int STAT_W = 6;
    localparam int FREQ_W = 16;

    localparam logic [7:0] CODE_GRST  = 8'h01;
    localparam logic [7:0] CODE_BASE0 = 8'h70;
    localparam logic [7:0] CODE_BASE1 = 8'h78;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_GRST,
        OP_CTRL_WR,
        OP_STAT_RD,
        OP_RXF_RD,
        OP_FREQ_WR,
        OP_RXD_RD,
        OP_TXD_WR,
        OP_GAIN_WR
    } op_e;

    function automatic op_e op_decode(input logic [7:0] code, input logic strap);
        logic [7:0] base;
        logic [7:0] off;
        op_e        res;
        base = strap ? CODE_BASE1 : CODE_BASE0;
        off  = code - base;
        res  = OP_NONE;
        if (code == CODE_GRST) begin
            res = OP_GRST;
        end else if (code >= base && off <= 8'd6) begin
            case (off[2:0])
                3'd0:    res = OP_CTRL_WR;
                3'd1:    res = OP_STAT_RD;
                3'd2:    res = OP_RXF_RD;
                3'd3:    res = OP_FREQ_WR;
                3'd4:    res = OP_RXD_RD;
                3'd5:    res = OP_TXD_WR;
                3'd6:    res = OP_GAIN_WR;
                default: res = OP_NONE;
            endcase
        end
        return res;
    endfunction

    function automatic logic [1:0] op_len(input op_e op);
        case (op)
            OP_NONE, OP_GRST:      return 2'd0;
            OP_RXF_RD, OP_FREQ_WR: return 2'd2;
            default:               return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/sig_regif_rx.sv
module sig_regif_rx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       cmd_in,
    output logic       rise,
    output logic       cs_idle,
    output logic       byte_done,
    output logic [7:0] byte_val
);
    localparam int CNT_W = 3;

    logic [SYNC_STAGES:0]   sclk_p;
    logic [SYNC_STAGES-1:0] cs_p;
    logic [SYNC_STAGES-1:0] dat_p;
    logic [CNT_W-1:0]       bit_cnt;
    logic [6:0]             sh;
    logic                   dat_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_p <= '0;
            cs_p   <= '1;
            dat_p  <= '0;
        end else begin
            sclk_p <= {sclk_p[SYNC_STAGES-1:0], sclk};
            cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
            dat_p  <= {dat_p[SYNC_STAGES-2:0], cmd_in};
        end
    end

    assign rise    = sclk_p[SYNC_STAGES-1] & ~sclk_p[SYNC_STAGES];
    assign cs_idle = cs_p[SYNC_STAGES-1];
    assign dat_s   = dat_p[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            sh        <= '0;
            byte_done <= 1'b0;
            byte_val  <= '0;
        end else begin
            byte_done <= 1'b0;
            if (cs_idle) begin
                bit_cnt <= '0;
            end else if (rise) begin
                sh      <= {sh[5:0], dat_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == 3'd7) begin
                    byte_done <= 1'b1;
                    byte_val  <= {sh, dat_s};
                end
            end
        end
    end

    // a frame that has ended yields no further byte
    assert_abort_R12: assert property (@(posedge clk) disable iff (rst)
        cs_idle |=> !byte_done);

endmodule

// File: rtl/sig_regif_status.sv
module sig_regif_status
    import sig_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat_set,
    input  logic [STAT_W-1:0] stat_clr,
    input  logic              status_rd,
    input  logic              gen_rst,
    input  logic              irq_enable,
    output logic [STAT_W-1:0] status_q,
    output logic              irq_act
);
    localparam logic [STAT_W-1:0] RD_CLR = STAT_W'(2'b11);

    logic [STAT_W-1:0] keep;

    always_comb begin
        keep = status_q & ~stat_clr;
        if (status_rd) keep = keep & ~RD_CLR;
    end

    always_ff @(posedge clk) begin
        if (rst || gen_rst) status_q <= '0;
        else                status_q <= keep | stat_set;
    end

    assign irq_act = irq_enable & (|status_q);

    assert_rdclr_R6: assert property (@(posedge clk) disable iff (rst)
        status_rd |=> ((status_q[1:0] & ~$past(stat_set[1:0])) == 2'b00));

    assert_grst_stat_R8: assert property (@(posedge clk) disable iff (rst)
        gen_rst |=> (status_q == '0));

endmodule

// File: rtl/sig_regif_engine.sv
module sig_regif_engine
    import sig_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap,
    input  logic              cs_idle,
    input  logic              rise,
    input  logic              byte_done,
    input  logic [7:0]        byte_val,
    input  logic [FREQ_W-1:0] rxfreq_in,
    input  logic [7:0]        rxdata_in,
    input  logic [STAT_W-1:0] status_in,
    output logic [7:0]        ctrl_q,
    output logic [FREQ_W-1:0] txfreq_q,
    output logic [7:0]        gain_q,
    output logic [7:0]        txdata_q,
    output logic              txdata_wr,
    output logic              rxdata_rd,
    output logic              status_rd,
    output logic              gen_rst,
    output logic              reply_bit,
    output logic              reply_en
);
    localparam int RSV_BIT = 3;   // bit 11 of the word, bit 3 of the high byte

    op_e        op;
    logic       got_cmd;
    logic [1:0] idx;
    logic [1:0] left;
    logic [2:0] rbit;
    logic [7:0] rsh;
    logic [7:0] rlo;
    op_e        op_new;
    logic       more;

    assign op_new = op_decode(byte_val, strap);
    assign more   = idx < op_len(op);

    always_ff @(posedge clk) begin
        if (rst) begin
            op        <= OP_NONE;
            got_cmd   <= 1'b0;
            idx       <= '0;
            left      <= '0;
            rbit      <= '0;
            rsh       <= '0;
            rlo       <= '0;
            ctrl_q    <= '0;
            txfreq_q  <= '0;
            gain_q    <= '0;
            txdata_q  <= '0;
            txdata_wr <= 1'b0;
            rxdata_rd <= 1'b0;
            status_rd <= 1'b0;
            gen_rst   <= 1'b0;
        end else begin
            txdata_wr <= 1'b0;
            rxdata_rd <= 1'b0;
            status_rd <= 1'b0;
            gen_rst   <= 1'b0;
            if (cs_idle) begin
                op      <= OP_NONE;
                got_cmd <= 1'b0;
                idx     <= '0;
                left    <= '0;
                rbit    <= '0;
            end else if (byte_done && !got_cmd) begin
                got_cmd <= 1'b1;
                op      <= op_new;
                idx     <= '0;
                rbit    <= '0;
                case (op_new)
                    OP_GRST: begin
                        gen_rst <= 1'b1;
                        ctrl_q  <= '0;
                    end
                    OP_STAT_RD: begin
                        rsh       <= {{(8-STAT_W){1'b0}}, status_in};
                        status_rd <= 1'b1;
                        left      <= 2'd1;
                    end
                    OP_RXF_RD: begin
                        rsh  <= rxfreq_in[15:8];
                        rlo  <= rxfreq_in[7:0];
                        left <= 2'd2;
                    end
                    OP_RXD_RD: begin
                        rsh       <= rxdata_in;
                        rxdata_rd <= 1'b1;
                        left      <= 2'd1;
                    end
                    default: left <= '0;
                endcase
            end else if (byte_done && more) begin
                idx <= idx + 1'b1;
                case (op)
                    OP_CTRL_WR: ctrl_q <= byte_val;
                    OP_GAIN_WR: gain_q <= byte_val;
                    OP_TXD_WR: begin
                        txdata_q  <= byte_val;
                        txdata_wr <= 1'b1;
                    end
                    OP_FREQ_WR: begin
                        if (idx == 2'd0) begin
                            txfreq_q[15:8] <= byte_val & ~(8'd1 << RSV_BIT);
                        end else begin
                            txfreq_q[7:0] <= byte_val;
                        end
                    end
                    default: ;
                endcase
            end else if (rise && left != 2'd0) begin
                rsh  <= {rsh[6:0], 1'b0};
                rbit <= rbit + 1'b1;
                if (rbit == 3'd7) begin
                    left <= left - 1'b1;
                    if (left == 2'd2) rsh <= rlo;
                end
            end
        end
    end

    assign reply_bit = rsh[7];
    assign reply_en  = (left != 2'd0);

    assert_reply_off_R9: assert property (@(posedge clk) disable iff (rst)
        cs_idle |=> !reply_en);

    assert_extra_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (byte_done && got_cmd && !more && !cs_idle) |=>
            ($stable(ctrl_q) && $stable(gain_q) && $stable(txfreq_q) && $stable(txdata_q)));

    assert_wr_single_R13: assert property (@(posedge clk) disable iff (rst)
        txdata_wr |=> !txdata_wr);

endmodule

// File: rtl/sig_regif.sv
module sig_regif
    import sig_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_sel,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              cmd_in,
    output wire               reply_out,
    output logic              reply_en,
    output wire               irq_n,
    output logic              irq_en,
    output logic [7:0]        ctrl_q,
    output logic [FREQ_W-1:0] txfreq_q,
    output logic [7:0]        gain_q,
    output logic [7:0]        txdata_q,
    output logic              txdata_wr,
    input  logic [FREQ_W-1:0] rxfreq_in,
    input  logic [7:0]        rxdata_in,
    output logic              rxdata_rd,
    input  logic [STAT_W-1:0] stat_set,
    input  logic [STAT_W-1:0] stat_clr
);
    localparam int IRQ_EN_BIT = 2;

    logic              rise;
    logic              cs_idle;
    logic              byte_done;
    logic [7:0]        byte_val;
    logic [STAT_W-1:0] status_q;
    logic              status_rd;
    logic              gen_rst;
    logic              reply_bit;

    sig_regif_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .cmd_in(cmd_in),
        .rise(rise), .cs_idle(cs_idle), .byte_done(byte_done), .byte_val(byte_val)
    );

    sig_regif_engine u_eng (
        .clk(clk), .rst(rst), .strap(addr_sel), .cs_idle(cs_idle), .rise(rise),
        .byte_done(byte_done), .byte_val(byte_val), .rxfreq_in(rxfreq_in),
        .rxdata_in(rxdata_in), .status_in(status_q), .ctrl_q(ctrl_q),
        .txfreq_q(txfreq_q), .gain_q(gain_q), .txdata_q(txdata_q),
        .txdata_wr(txdata_wr), .rxdata_rd(rxdata_rd), .status_rd(status_rd),
        .gen_rst(gen_rst), .reply_bit(reply_bit), .reply_en(reply_en)
    );

    sig_regif_status u_stat (
        .clk(clk), .rst(rst), .stat_set(stat_set), .stat_clr(stat_clr),
        .status_rd(status_rd), .gen_rst(gen_rst), .irq_enable(ctrl_q[IRQ_EN_BIT]),
        .status_q(status_q), .irq_act(irq_en)
    );

    assign reply_out = reply_en ? reply_bit : 1'bz;
    assign irq_n     = irq_en ? 1'b0 : 1'bz;

    // after a general reset no interrupt can be pending
    assert_grst_irq_R7: assert property (@(posedge clk) disable iff (rst)
        gen_rst |=> !irq_en);

endmodule

// File: tb/test_sig_regif.sv
module test_sig_regif;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_sel = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        cmd_in = 1'b0;
    wire         reply_out;
    logic        reply_en;
    wire         irq_n;
    logic        irq_en;
    logic [7:0]  ctrl_q;
    logic [15:0] txfreq_q;
    logic [7:0]  gain_q;
    logic [7:0]  txdata_q;
    logic        txdata_wr;
    logic [15:0] rxfreq_in = 16'hBEEF;
    logic [7:0]  rxdata_in = 8'h69;
    logic        rxdata_rd;
    logic [5:0]  stat_set = '0;
    logic [5:0]  stat_clr = '0;

    sig_regif i_sig_regif (
        .clk(clk), .rst(rst), .addr_sel(addr_sel), .sclk(sclk), .cs_n(cs_n),
        .cmd_in(cmd_in), .reply_out(reply_out), .reply_en(reply_en), .irq_n(irq_n),
        .irq_en(irq_en), .ctrl_q(ctrl_q), .txfreq_q(txfreq_q), .gain_q(gain_q),
        .txdata_q(txdata_q), .txdata_wr(txdata_wr), .rxfreq_in(rxfreq_in),
        .rxdata_in(rxdata_in), .rxdata_rd(rxdata_rd), .stat_set(stat_set),
        .stat_clr(stat_clr)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int en_cnt = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    bit busy = 1'b1;

    // behavioural model state
    logic [7:0]  ctrl_m = '0;
    logic [15:0] freq_m = '0;
    logic [7:0]  gain_m = '0;
    logic [7:0]  txd_m = '0;
    logic [5:0]  stat_m = '0;

    always @(posedge clk) begin
        if (reply_en)  en_cnt++;
        if (txdata_wr) wr_cnt++;
        if (rxdata_rd) rd_cnt++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model comparison on every quiet clock
    always @(negedge clk) begin
        if (!rst && !busy) begin
            check(ctrl_q == ctrl_m,  "R2 ctrl",   ctrl_q,   ctrl_m);
            check(txfreq_q == freq_m, "R4 freq",  txfreq_q, freq_m);
            check(gain_q == gain_m,  "R10 gain",  gain_q,   gain_m);
            check(txdata_q == txd_m, "R13 txd",   txdata_q, txd_m);
            check(irq_en == (ctrl_m[2] && |stat_m), "R7 irq", irq_en, ctrl_m[2] && |stat_m);
            check(!reply_en, "R9 idle reply", reply_en, 0);
        end
    end

    task automatic settle();
        repeat (8) @(negedge clk);
        busy = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            cmd_in = b[i];
            repeat (HALF) @(negedge clk);
            r[i] = reply_en ? reply_out : 1'b0;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    // frame: n full bytes, then optionally k bits of a trailing byte
    task automatic frame(input int n, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input int k,
                         output logic [7:0] r1, output logic [7:0] r2, output int en_seen);
        logic [7:0] dummy;
        int e0;
        busy = 1'b1;
        @(negedge clk);
        e0 = en_cnt;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        send_bits(b0, 8, dummy);
        r1 = '0;
        r2 = '0;
        if (n > 1) send_bits(b1, 8, r1);
        if (n > 2) send_bits(b2, 8, r2);
        if (k > 0) send_bits(n > 1 ? b2 : b1, k, dummy);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        en_seen = en_cnt - e0;
    endtask

    task automatic pulse_stat(input logic [5:0] s, input logic [5:0] c);
        busy = 1'b1;
        @(negedge clk);
        stat_set = s;
        stat_clr = c;
        @(negedge clk);
        stat_set = '0;
        stat_clr = '0;
        stat_m = (stat_m & ~c) | s;
        settle();
    endtask

    initial begin
        logic [7:0] r1, r2;
        int en;
        int w0, d0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ctrl_q == 0 && txfreq_q == 0 && gain_q == 0 && txdata_q == 0, "R1 regs", ctrl_q, 0);
        check(!reply_en && !irq_en, "R1 drive", {reply_en, irq_en}, 0);
        settle();

        // R2 control write, strap 0
        frame(2, 8'h70, 8'hA5, 8'h00, 0, r1, r2, en);
        ctrl_m = 8'hA5;
        check(en == 0, "R9 no reply on write", en, 0);
        settle();

        // R10 gain write with a surplus byte
        frame(3, 8'h76, 8'h3C, 8'hFF, 0, r1, r2, en);
        gain_m = 8'h3C;
        settle();

        // R4 frequency write, bit 11 masked
        frame(3, 8'h73, 8'hFF, 8'h12, 0, r1, r2, en);
        freq_m = 16'hF712;
        settle();
        // R4 first byte alone takes effect
        frame(2, 8'h73, 8'h5A, 8'h00, 0, r1, r2, en);
        freq_m[15:8] = 8'h52;
        settle();

        // R12 partial byte after control opcode
        frame(1, 8'h70, 8'h00, 8'h00, 4, r1, r2, en);
        settle();

        // R5 measured frequency read
        frame(3, 8'h72, 8'h00, 8'h00, 0, r1, r2, en);
        check(r1 == 8'hBE, "R5 high byte", r1, 8'hBE);
        check(r2 == 8'hEF, "R5 low byte", r2, 8'hEF);
        check(en > 0, "R9 reply driven on read", en, 1);
        settle();

        // R13 strobes
        w0 = wr_cnt;
        d0 = rd_cnt;
        frame(2, 8'h75, 8'hC3, 8'h00, 0, r1, r2, en);
        txd_m = 8'hC3;
        check(wr_cnt - w0 == 1, "R13 write strobe", wr_cnt - w0, 1);
        frame(2, 8'h74, 8'h00, 8'h00, 0, r1, r2, en);
        check(r1 == 8'h69, "R13 rx byte", r1, 8'h69);
        check(rd_cnt - d0 == 1, "R13 read strobe", rd_cnt - d0, 1);
        settle();

        // R6 / R7 status and interrupt
        pulse_stat(6'b100101, 6'b0);
        check(irq_en == 1'b1, "R7 irq asserted", irq_en, 1);
        frame(2, 8'h71, 8'h00, 8'h00, 0, r1, r2, en);
        check(r1 == 8'h25, "R6 status read", r1, 8'h25);
        stat_m = stat_m & 6'b111100;
        settle();
        frame(2, 8'h71, 8'h00, 8'h00, 0, r1, r2, en);
        check(r1 == 8'h24, "R6 after clear", r1, 8'h24);
        settle();
        pulse_stat(6'b0, 6'b100100);
        check(irq_en == 1'b0, "R7 irq released", irq_en, 0);
        pulse_stat(6'b001000, 6'b0);
        frame(2, 8'h70, 8'h00, 8'h00, 0, r1, r2, en);
        ctrl_m = 8'h00;
        settle();
        check(irq_en == 1'b0, "R7 masked", irq_en, 0);

        // R11 unknown opcodes, R3 other window under strap 0
        frame(2, 8'h7F, 8'h11, 8'h00, 0, r1, r2, en);
        check(en == 0, "R11 no reply 7F", en, 0);
        frame(2, 8'h77, 8'h22, 8'h00, 0, r1, r2, en);
        check(en == 0, "R11 no reply 77", en, 0);
        frame(2, 8'h79, 8'h00, 8'h00, 0, r1, r2, en);
        check(en == 0, "R3 strap0 ignores 79", en, 0);
        settle();

        // R3 strap 1
        addr_sel = 1'b1;
        frame(2, 8'h70, 8'h55, 8'h00, 0, r1, r2, en);
        settle();
        frame(2, 8'h78, 8'h5E, 8'h00, 0, r1, r2, en);
        ctrl_m = 8'h5E;
        frame(2, 8'h7E, 8'h81, 8'h00, 0, r1, r2, en);
        gain_m = 8'h81;
        settle();
        frame(2, 8'h79, 8'h00, 8'h00, 0, r1, r2, en);
        check(r1 == {2'b00, stat_m}, "R3 strap1 status", r1, {2'b00, stat_m});
        stat_m = stat_m & 6'b111100;
        settle();

        // R8 general reset
        pulse_stat(6'b010000, 6'b0);
        check(irq_en == 1'b1, "R8 pre irq", irq_en, 1);
        frame(2, 8'h01, 8'h99, 8'h00, 0, r1, r2, en);
        ctrl_m = 8'h00;
        stat_m = '0;
        settle();
        frame(2, 8'h79, 8'h00, 8'h00, 0, r1, r2, en);
        check(r1 == 8'h00, "R8 status cleared", r1, 0);
        settle();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule